// File: doc/BRIEF.md
# Overlapped Block Load Controller

This controller sequences the loading of sample blocks into the input buffer of a transform engine. One sample may be written on every clock. For each write the controller produces a buffer address and a strobe for the real sample port, the auxiliary sample port, or both. When a block has been loaded it issues a one-cycle block-loaded pulse to the engine. The engine itself is outside this block, and so is the external delay FIFO that feeds the real port one block late when one source is overlapped.

Loads are started by the input-enable line. It can act as a level enable that gates each sample, or as an edge trigger that must be re-armed after every block. In configurations with several devices, a rising edge on the frame-define line can also start a load.

The overlap setting fixes how many new samples make up one load sequence: N, N/2 or N/4. It also sets the start address of each sequence in the N-entry buffer, and whether block-loaded pulses are thinned out for output decimation.

Top module: `block_load_ctrl`

## Requirements
- R1: While `rst` is high, on the following edge `realWe`, `auxWe` and `blockDone` are 0 and `wrAddr` is 0.
- R2: With `overlapMode` = 000 (one source, no overlap), writes strobe only `realWe`, and `auxWe` stays 0.
- R3: With `overlapMode` 001, 010, 011 or 100 (one source, overlapped), every write strobes `realWe` and `auxWe` together at the same address.
- R4: A load sequence is H consecutive writes, where H = N for modes 000 and 101, H = N/2 for modes 001, 010 and 110, and H = N/4 for modes 011, 100 and 111. Sequence k (counted from 0 after reset) writes addresses (k*H + i) mod N for i = 0..H-1. `blockDone` is high together with the last write of a sequence.
- R5: In mode 010 `blockDone` is raised only on the 2nd, 4th, 6th… completed sequence. In mode 100 it is raised only on the 4th, 8th… completed sequence.
- R6: With `devMode` = 00 and `levelStyle` = 1, a write occurs in exactly those cycles in which `inen` was sampled high. There is no idle wait between sequences.
- R7: With `devMode` = 00 and `levelStyle` = 0, a rising edge of `inen` (low on the previous edge, high now) starts a sequence of H writes on consecutive clocks, whatever `inen` does meanwhile. Once the sequence ends, no write occurs until the next rising edge. A level held high does not restart it.
- R8: With `devMode` other than 00 and `levelStyle` = 0, only a rising edge of `inen` starts a sequence, and `defIn` has no effect.
- R9: With `devMode` other than 00 and `levelStyle` = 1, a rising edge of either `inen` or `defIn` starts a sequence.
- R10: With `overlapMode` 101, 110 or 111 (two independent sources), every write strobes both `realWe` and `auxWe`, and `blockDone` is never suppressed.
- R11: The outputs are registered. The inputs sampled on the edge that performs a write appear on `realData`/`auxData`, together with the strobes and `wrAddr`, just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| inen | input | 1 | Input enable / load trigger |
| defIn | input | 1 | Frame-define line from other devices |
| overlapMode | input | 3 | Overlap and source selection, encoded as in R2–R5 and R10 |
| devMode | input | 2 | 00 single device, 01 N devices concurrent, 10 N devices sequential, 11 multi-transform |
| levelStyle | input | 1 | 1 selects level enable (single device) or frame-define start (multi device) |
| realIn | input | DATA_W | Real-port sample |
| auxIn | input | DATA_W | Auxiliary-port sample |
| wrAddr | output | log2(BLOCK_LEN) | Buffer write address |
| realWe | output | 1 | Real-port write strobe |
| auxWe | output | 1 | Auxiliary-port write strobe |
| realData | output | DATA_W | Registered real sample |
| auxData | output | DATA_W | Registered auxiliary sample |
| blockDone | output | 1 | One-cycle block-loaded pulse |

## Verification
The critical coincidence is a fresh start condition, a rising `inen` or `defIn`, arriving on the very clock that carries the last write of a sequence. The design must ignore it and not chain straight into the next block. Edge toggling is randomised at a low rate so that such edges land on and just after sequence ends in every overlap and device configuration. Each cycle is judged against a bench model of the requirements, which predicts strobes, addresses and decimated pulses. Directed runs that hold `inen` or `defIn` high add a count of writes per sequence.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef struct packed {
    logic realWr;
    logic auxWr;
    logic done;
  } loadStrobe_t;

  // log2 of the ratio N / hop for each overlap code
  function automatic logic [1:0] hopShiftOf(input logic [2:0] mode);
    case (mode)
      3'b001, 3'b010, 3'b110: hopShiftOf = 2'd1;
      3'b011, 3'b100, 3'b111: hopShiftOf = 2'd2;
      default:                hopShiftOf = 2'd0;
    endcase
  endfunction

  // completed sequences per emitted pulse
  function automatic logic [2:0] decimOf(input logic [2:0] mode);
    case (mode)
      3'b010:  decimOf = 3'd2;
      3'b100:  decimOf = 3'd4;
      default: decimOf = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/lbc_ctrl.sv
module lbc_ctrl
  import lbc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inen,
  input  logic          defIn,
  input  logic [2:0]    overlapMode,
  input  logic [1:0]    devMode,
  input  logic          levelStyle,
  output loadStrobe_t   stb,
  output logic [AW-1:0] addrNext
);

  logic          inenQ, defQ, loading;
  logic [AW-1:0] offset;
  logic [1:0]    seg;
  logic [1:0]    decCnt;

  logic          inenRise, defRise, levelMode, startReq, go, last, decHit;
  logic [1:0]    shift;
  logic [2:0]    div;
  logic [31:0]   hopLen, segTerm;

  always_comb begin
    inenRise  = inen & ~inenQ;
    defRise   = defIn & ~defQ;
    levelMode = (devMode == 2'b00) && levelStyle;
    startReq  = inenRise | ((devMode != 2'b00) && levelStyle && defRise);
    go        = levelMode ? inen : (loading | startReq);
    shift     = hopShiftOf(overlapMode);
    div       = decimOf(overlapMode);
    hopLen    = 32'd1 << (AW - int'(shift));
    last      = (32'(offset) == hopLen - 32'd1);
    segTerm   = 32'(seg) << (AW - int'(shift));
    addrNext  = offset + segTerm[AW-1:0];
    decHit    = (div == 3'd1) || ({1'b0, decCnt} == div - 3'd1);
    stb.realWr = go;
    stb.auxWr  = go && (overlapMode != 3'b000);
    stb.done   = go && last && decHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inenQ   <= 1'b0;
      defQ    <= 1'b0;
      loading <= 1'b0;
      offset  <= '0;
      seg     <= '0;
      decCnt  <= '0;
    end else begin
      inenQ <= inen;
      defQ  <= defIn;
      if (go) begin
        loading <= !levelMode && !last;
        if (last) begin
          offset <= '0;
          seg    <= seg + 2'd1;
          if (div == 3'd1 || decHit) decCnt <= '0;
          else                       decCnt <= decCnt + 2'd1;
        end else begin
          offset <= offset + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lbc_dpath.sv
module lbc_dpath
  import lbc_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  loadStrobe_t       stb,
  input  logic [AW-1:0]     addrNext,
  input  logic [DATA_W-1:0] realIn,
  input  logic [DATA_W-1:0] auxIn,
  output logic [AW-1:0]     wrAddr,
  output logic              realWe,
  output logic              auxWe,
  output logic [DATA_W-1:0] realData,
  output logic [DATA_W-1:0] auxData,
  output logic              blockDone
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrAddr    <= '0;
      realWe    <= 1'b0;
      auxWe     <= 1'b0;
      realData  <= '0;
      auxData   <= '0;
      blockDone <= 1'b0;
    end else begin
      realWe    <= stb.realWr;
      auxWe     <= stb.auxWr;
      blockDone <= stb.done;
      if (stb.realWr) begin
        wrAddr   <= addrNext;
        realData <= realIn;
      end
      if (stb.auxWr) auxData <= auxIn;
    end
  end

endmodule

// File: rtl/block_load_ctrl.sv
module block_load_ctrl
  import lbc_pkg::*;
#(
  parameter int BLOCK_LEN = 16,
  parameter int DATA_W    = 12,
  localparam int AW       = $clog2(BLOCK_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inen,
  input  logic              defIn,
  input  logic [2:0]        overlapMode,
  input  logic [1:0]        devMode,
  input  logic              levelStyle,
  input  logic [DATA_W-1:0] realIn,
  input  logic [DATA_W-1:0] auxIn,
  output logic [AW-1:0]     wrAddr,
  output logic              realWe,
  output logic              auxWe,
  output logic [DATA_W-1:0] realData,
  output logic [DATA_W-1:0] auxData,
  output logic              blockDone
);

  loadStrobe_t   stb;
  logic [AW-1:0] addrNext;

  lbc_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .inen(inen), .defIn(defIn),
    .overlapMode(overlapMode), .devMode(devMode), .levelStyle(levelStyle),
    .stb(stb), .addrNext(addrNext)
  );

  lbc_dpath #(.AW(AW), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .addrNext(addrNext),
    .realIn(realIn), .auxIn(auxIn),
    .wrAddr(wrAddr), .realWe(realWe), .auxWe(auxWe),
    .realData(realData), .auxData(auxData), .blockDone(blockDone)
  );

endmodule

// File: rtl/block_load_ctrl_chk.sv
module block_load_ctrl_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          inen,
  input logic [2:0]    overlapMode,
  input logic [1:0]    devMode,
  input logic          levelStyle,
  input logic [AW-1:0] wrAddr,
  input logic          realWe,
  input logic          auxWe,
  input logic          blockDone
);

  // R2
  aux_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (overlapMode == 3'b000) |-> !auxWe);

  // R3
  paired_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (overlapMode != 3'b000) |-> (auxWe == realWe));

  // R4
  done_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    blockDone |-> realWe);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && realWe && $past(realWe) && !$past(blockDone) &&
     overlapMode != 3'b010 && overlapMode != 3'b100)
    |-> (wrAddr == $past(wrAddr) + 1'b1));

  // R6
  level_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && devMode == 2'b00 && levelStyle) |-> (realWe == $past(inen)));

endmodule

bind block_load_ctrl block_load_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .inen(inen), .overlapMode(overlapMode),
  .devMode(devMode), .levelStyle(levelStyle), .wrAddr(wrAddr),
  .realWe(realWe), .auxWe(auxWe), .blockDone(blockDone)
);

// File: tb/block_load_ctrl_bench.sv
`timescale 1ns/1ps
module block_load_ctrl_bench;
  localparam int N  = 16;
  localparam int DW = 12;
  localparam int AW = $clog2(N);

  logic clk = 0, rst = 1, inen = 0, defIn = 0, levelStyle = 0;
  logic [2:0] overlapMode = 0;
  logic [1:0] devMode = 0;
  logic [DW-1:0] realIn = 0, auxIn = 0;
  logic [AW-1:0] wrAddr;
  logic realWe, auxWe, blockDone;
  logic [DW-1:0] realData, auxData;

  int total = 0, bad = 0;
  bit finished = 0;

  // model state
  bit mLoad, mInQ, mDefQ;
  int mOff, mSeg, mDec;
  bit eWe, eAux, eDone;
  int eAddr, eReal, eAuxD;

  always #10 clk = ~clk;

  block_load_ctrl #(.BLOCK_LEN(N), .DATA_W(DW)) u_block_load_ctrl (
    .clk(clk), .rst(rst), .inen(inen), .defIn(defIn), .overlapMode(overlapMode),
    .devMode(devMode), .levelStyle(levelStyle), .realIn(realIn), .auxIn(auxIn),
    .wrAddr(wrAddr), .realWe(realWe), .auxWe(auxWe), .realData(realData),
    .auxData(auxData), .blockDone(blockDone)
  );

  function automatic int hopOf(input logic [2:0] m);
    if (m == 3'b000 || m == 3'b101) return N;
    if (m == 3'b001 || m == 3'b010 || m == 3'b110) return N / 2;
    return N / 4;
  endfunction

  function automatic int divOf(input logic [2:0] m);
    if (m == 3'b010) return 2;
    if (m == 3'b100) return 4;
    return 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mLoad = 0; mInQ = 0; mDefQ = 0; mOff = 0; mSeg = 0; mDec = 0;
  endtask

  task automatic modelStep();
    bit lvl, start, go, last;
    int hop;
    hop   = hopOf(overlapMode);
    lvl   = (devMode == 0) && levelStyle;
    start = (inen && !mInQ) || (devMode != 0 && levelStyle && defIn && !mDefQ);
    go    = lvl ? inen : (mLoad || start);
    last  = (mOff == hop - 1);
    eWe   = go;
    eAux  = go && (overlapMode != 0);
    eDone = 0;
    if (go) begin
      eAddr = (mOff + mSeg * hop) % N;
      eReal = int'(realIn);
      if (eAux) eAuxD = int'(auxIn);
      mLoad = !lvl && !last;
      if (last) begin
        mOff = 0;
        mSeg++;
        mDec++;
        if (mDec == divOf(overlapMode)) begin
          eDone = 1;
          mDec = 0;
        end
      end else mOff++;
    end
    mInQ = inen;
    mDefQ = defIn;
  endtask

  task automatic startTagged(output string st, output string at);
    if (devMode == 0) st = levelStyle ? "R6" : "R7";
    else st = levelStyle ? "R9" : "R8";
    if (overlapMode == 0) at = "R2";
    else if (overlapMode >= 5) at = "R10";
    else at = "R3";
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; inen = 0; defIn = 0;
    @(posedge clk); @(posedge clk); #1;
    check("R1 realWe", int'(realWe), 0);
    check("R1 auxWe", int'(auxWe), 0);
    check("R1 blockDone", int'(blockDone), 0);
    check("R1 wrAddr", int'(wrAddr), 0);
    modelReset();
    eReal = 0; eAuxD = 0; eAddr = 0;
    @(negedge clk);
    rst = 0;
  endtask

  // drives one cycle, returns observed write strobe
  task automatic runCycle(input bit iv, input bit dv, output bit wrote);
    string st, at;
    startTagged(st, at);
    if (!rst) @(negedge clk);
    inen = iv; defIn = dv;
    realIn = DW'($urandom); auxIn = DW'($urandom);
    modelStep();
    @(posedge clk); #1;
    check(st, int'(realWe), int'(eWe));
    check(at, int'(auxWe), int'(eAux));
    check((overlapMode == 2 || overlapMode == 4) ? "R5" : "R4",
          int'(blockDone), int'(eDone));
    if (eWe) begin
      check("R4 addr", int'(wrAddr), eAddr);
      check("R11 realData", int'(realData), eReal);
    end
    if (eAux) check("R11 auxData", int'(auxData), eAuxD);
    wrote = realWe;
  endtask

  task automatic randomRun(input logic [2:0] om, input logic [1:0] dm, input bit ls);
    bit w, iv, dv;
    overlapMode = om; devMode = dm; levelStyle = ls;
    doReset();
    iv = 0; dv = 0;
    for (int c = 0; c < 200; c++) begin
      if (dm == 0 && ls) iv = bit'($urandom_range(0, 1));
      else if ($urandom_range(0, 3) == 0) iv = ~iv;
      if ($urandom_range(0, 5) == 0) dv = ~dv;
      runCycle(iv, dv, w);
    end
  endtask

  task automatic directed(input logic [2:0] om, input logic [1:0] dm, input bit ls,
                          input bit viaDef, input int expCount, input string tag);
    bit w;
    int cnt;
    overlapMode = om; devMode = dm; levelStyle = ls;
    doReset();
    cnt = 0;
    for (int c = 0; c < 3 * N; c++) begin
      runCycle(!viaDef, viaDef, w);
      cnt += int'(w);
    end
    check(tag, cnt, expCount);
  endtask

  initial begin
    void'($urandom(32'd4711));
    // held-high enable writes exactly one sequence (R7)
    directed(3'b000, 2'd0, 1'b0, 1'b0, N, "R7 held-high count");
    directed(3'b011, 2'd0, 1'b0, 1'b0, N / 4, "R7 quarter-hop count");
    // frame define ignored / honoured (R8, R9)
    directed(3'b000, 2'd1, 1'b0, 1'b1, 0, "R8 def ignored count");
    directed(3'b110, 2'd2, 1'b1, 1'b1, N / 2, "R9 def start count");
    // level enable held high writes every cycle (R6)
    directed(3'b001, 2'd0, 1'b1, 1'b0, 3 * N, "R6 level count");
    for (int m = 0; m < 8; m++) begin
      randomRun(3'(m), 2'd0, 1'b0);
      randomRun(3'(m), 2'd0, 1'b1);
      randomRun(3'(m), 2'd1, 1'b0);
      randomRun(3'(m), 2'd2, 1'b1);
      randomRun(3'(m), 2'd3, 1'b1);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule